// File: doc/BRIEF.md
# Parallel Port with Expansion-Address Override

This block is an 8-bit parallel I/O port on a simple register bus. Four registers control it: an output data latch, a per-pin direction mask, a per-pin assignment mask that hands a pin to the memory-expansion logic, and a per-pin pull-up enable. The two upper pins can only be inputs. Their levels also go out as the analog channel select lines. The six lower pins are bidirectional.

Any lower pin can be taken over by one extended address line from the memory-expansion logic. Lower pin n carries address bit 13+n, so pin 0 carries bit 13 and pin 5 carries bit 18. These bits arrive on a 6-bit input vector. While a pin is taken over, software writes to the data register still change the latch, but the pin does not show them. The latch has no reset, so a value written before a reset is still there after it.

For each pin the block produces output data, an output enable and a pull-up enable. It reads the pin levels back through the data register.

Top module: `gpio_altport`

## Requirements
- R1: After reset, the direction, assignment and pull-up registers read as zero, and every pin_oe and pin_pu bit is 0.
- R2: pin_oe[7:6] and pin_out[7:6] are always 0, whatever is written to direction bits 7 and 6.
- R3: A lower pin n whose assignment bit is 0 has pin_oe[n] equal to direction bit n and pin_out[n] equal to latch bit n.
- R4: A lower pin n whose assignment bit is 1 has pin_oe[n]=1 and pin_out[n]=xaddr_in[n] (address bit 13+n), whatever direction bit n holds.
- R5: A data write to a pin in alternate mode changes the latch but leaves pin_out unchanged. Once the assignment bit is cleared, the new latch value appears on the pin.
- R6: A data register read returns, for each bit n, the latch bit when n<6, direction bit n is 1 and assignment bit n is 0, and pin_in[n] in every other case.
- R7: pin_pu[n] for n<6 is the pull-up bit n ANDed with NOT direction bit n and NOT assignment bit n. pin_pu[7:6] is always 0.
- R8: an_sel[1:0] always equals pin_in[7:6].
- R9: The register offsets are: data 0x7E, direction 0x7F, assignment 0x7D (bits 5:0), pull-up 0x7C (bits 5:0). The unused upper bits of the 6-bit registers read as 0. A read at any other offset returns 0, and a write there changes no register.
- R10: Reset does not change the data latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |
| xaddr_in | input | 6 | Extended address bits 13 to 18 |
| an_sel | output | 2 | Upper pin levels for the analog channel select |

## Verification
The assertions assume three things about the inputs. The bus makes at most one access per cycle. xaddr_in changes only between clock edges. Nothing accesses the port while reset is held or while the reset synchronizer is still releasing. The hidden-write property also assumes that an address bit which must not move stays stable. The bench meets all of this: it drives every input at the falling edge, keeps the bus idle during reset, and changes xaddr_in only while it is checking steady outputs.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned LOW_W  = 6;
  localparam int unsigned ADDR_W = 8;

  localparam logic [7:0] OFS_DATA = 8'h7E;
  localparam logic [7:0] OFS_DIR  = 8'h7F;
  localparam logic [7:0] OFS_ALT  = 8'h7D;
  localparam logic [7:0] OFS_PULL = 8'h7C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_ALT,
    SEL_PULL
  } reg_sel_e;
endpackage

// File: rtl/gpio_altport_regs.sv
module gpio_altport_regs
  import gpio_altport_pkg::*;
#(
  parameter int unsigned PORT_W = gpio_altport_pkg::PORT_W,
  parameter int unsigned LOW_W  = gpio_altport_pkg::LOW_W,
  parameter int unsigned ADDR_W = gpio_altport_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output reg_sel_e          reg_sel,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [LOW_W-1:0]  alt_q,
  output logic [LOW_W-1:0]  pull_q
);
  logic [PORT_W-1:0] dir_d;
  logic [LOW_W-1:0]  alt_d, pull_d;
  logic              latch_en;

  // address decode
  always_comb begin
    reg_sel = SEL_NONE;
    if (bus_sel) begin
      if      (bus_addr == ADDR_W'(OFS_DATA)) reg_sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(OFS_DIR))  reg_sel = SEL_DIR;
      else if (bus_addr == ADDR_W'(OFS_ALT))  reg_sel = SEL_ALT;
      else if (bus_addr == ADDR_W'(OFS_PULL)) reg_sel = SEL_PULL;
    end
  end

  // next state
  always_comb begin
    dir_d    = dir_q;
    alt_d    = alt_q;
    pull_d   = pull_q;
    latch_en = 1'b0;
    if (bus_wr) begin
      case (reg_sel)
        SEL_DATA: latch_en = 1'b1;
        SEL_DIR:  dir_d    = bus_wdata;
        SEL_ALT:  alt_d    = bus_wdata[LOW_W-1:0];
        SEL_PULL: pull_d   = bus_wdata[LOW_W-1:0];
        default:  ;
      endcase
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      alt_q  <= '0;
      pull_q <= '0;
    end else begin
      dir_q  <= dir_d;
      alt_q  <= alt_d;
      pull_q <= pull_d;
    end
  end

  // data latch has no reset by intent
  always_ff @(posedge clk) begin
    if (latch_en) latch_q <= bus_wdata;
  end

  p_cfg_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0 && alt_q == '0 && pull_q == '0));

  p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DATA)) |=> latch_q == $past(bus_wdata));
endmodule

// File: rtl/gpio_altport_pinmux.sv
module gpio_altport_pinmux #(
  parameter int unsigned PORT_W = gpio_altport_pkg::PORT_W,
  parameter int unsigned LOW_W  = gpio_altport_pkg::LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOW_W-1:0]  latch_lo,
  input  logic [LOW_W-1:0]  dir_lo,
  input  logic [LOW_W-1:0]  alt_q,
  input  logic [LOW_W-1:0]  pull_q,
  input  logic [LOW_W-1:0]  xaddr_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu
);
  for (genvar n = 0; n < PORT_W; n++) begin : g_pin
    if (n < LOW_W) begin : g_bidir
      assign pin_out[n] = alt_q[n] ? xaddr_in[n] : latch_lo[n];
      assign pin_oe[n]  = alt_q[n] | dir_lo[n];
      assign pin_pu[n]  = pull_q[n] & ~dir_lo[n] & ~alt_q[n];

      p_alt_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alt_q[n] |-> (pin_oe[n] && pin_out[n] == xaddr_in[n]));
    end else begin : g_inonly
      assign pin_out[n] = 1'b0;
      assign pin_oe[n]  = 1'b0;
      assign pin_pu[n]  = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_altport_rdmux.sv
module gpio_altport_rdmux
  import gpio_altport_pkg::*;
#(
  parameter int unsigned PORT_W = gpio_altport_pkg::PORT_W,
  parameter int unsigned LOW_W  = gpio_altport_pkg::LOW_W
) (
  input  reg_sel_e          reg_sel,
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [LOW_W-1:0]  alt_q,
  input  logic [LOW_W-1:0]  pull_q,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] rdata
);
  localparam int unsigned HI_W = PORT_W - LOW_W;

  logic [PORT_W-1:0] gp_out_mask;
  logic [PORT_W-1:0] data_view;

  assign gp_out_mask = {{HI_W{1'b0}}, dir_q[LOW_W-1:0] & ~alt_q};
  assign data_view   = (latch_q & gp_out_mask) | (pin_in & ~gp_out_mask);

  always_comb begin
    case (reg_sel)
      SEL_DATA: rdata = data_view;
      SEL_DIR:  rdata = dir_q;
      SEL_ALT:  rdata = PORT_W'(alt_q);
      SEL_PULL: rdata = PORT_W'(pull_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
  import gpio_altport_pkg::*;
#(
  parameter int unsigned PORT_W = gpio_altport_pkg::PORT_W,
  parameter int unsigned LOW_W  = gpio_altport_pkg::LOW_W,
  parameter int unsigned ADDR_W = gpio_altport_pkg::ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [PORT_W-1:0]       bus_wdata,
  output logic [PORT_W-1:0]       bus_rdata,
  input  logic [PORT_W-1:0]       pin_in,
  output logic [PORT_W-1:0]       pin_out,
  output logic [PORT_W-1:0]       pin_oe,
  output logic [PORT_W-1:0]       pin_pu,
  input  logic [LOW_W-1:0]        xaddr_in,
  output logic [PORT_W-LOW_W-1:0] an_sel
);
  localparam int unsigned HI_W = PORT_W - LOW_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  reg_sel_e          reg_sel;
  logic [PORT_W-1:0] latch_q, dir_q;
  logic [LOW_W-1:0]  alt_q, pull_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  gpio_altport_regs #(.PORT_W(PORT_W), .LOW_W(LOW_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reg_sel   (reg_sel),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .alt_q     (alt_q),
    .pull_q    (pull_q)
  );

  gpio_altport_pinmux #(.PORT_W(PORT_W), .LOW_W(LOW_W)) u_pinmux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .latch_lo (latch_q[LOW_W-1:0]),
    .dir_lo   (dir_q[LOW_W-1:0]),
    .alt_q    (alt_q),
    .pull_q   (pull_q),
    .xaddr_in (xaddr_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu)
  );

  gpio_altport_rdmux #(.PORT_W(PORT_W), .LOW_W(LOW_W)) u_rdmux (
    .reg_sel (reg_sel),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .alt_q   (alt_q),
    .pull_q  (pull_q),
    .pin_in  (pin_in),
    .rdata   (bus_rdata)
  );

  assign an_sel = pin_in[PORT_W-1:LOW_W];

  p_top_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe[PORT_W-1:LOW_W] == '0 && pin_out[PORT_W-1:LOW_W] == '0));

  p_pull_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_pu & pin_oe) == '0);

  for (genvar n = 0; n < LOW_W; n++) begin : g_hidden
    p_alt_hidden_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (alt_q[n] && $past(alt_q[n]) && $stable(xaddr_in[n])) |-> $stable(pin_out[n]));
  end

  if (HI_W == 0) begin : g_bad_split
    initial $error("gpio_altport: LOW_W must be below PORT_W");
  end
endmodule

// File: tb/gpio_altport_tb.sv
module gpio_altport_tb;
  localparam int PW = 8;
  localparam int LW = 6;
  localparam logic [7:0] A_DATA = 8'h7E, A_DIR = 8'h7F, A_ALT = 8'h7D, A_PULL = 8'h7C;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [7:0]    bus_addr, bus_wdata, bus_rdata;
  logic [PW-1:0] pin_in, pin_out, pin_oe, pin_pu;
  logic [LW-1:0] xaddr_in;
  logic [1:0]    an_sel;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_altport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .xaddr_in(xaddr_in), .an_sel(an_sel)
  );

  // stimulus vectors: dir, alt, pull, latch, xaddr, pin_in
  typedef struct packed {
    logic [7:0] dir;
    logic [5:0] alt;
    logic [5:0] pull;
    logic [7:0] latch;
    logic [5:0] xa;
    logic [7:0] pin;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h3F, 6'h00, 6'h3F, 8'hA5, 6'h2A, 8'h0F},
    '{8'h00, 6'h00, 6'h3F, 8'h5A, 6'h15, 8'hC3},
    '{8'hFF, 6'h3F, 6'h00, 8'h00, 6'h2D, 8'h81},
    '{8'h0F, 6'h33, 6'h2A, 8'hF0, 6'h0C, 8'h55},
    '{8'hC5, 6'h18, 6'h07, 8'h3C, 6'h3F, 8'hAA},
    '{8'h24, 6'h09, 6'h3F, 8'hFF, 6'h00, 8'h7E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // expectations derived from the requirements
  function automatic logic [7:0] m_oe(vec_t v);
    return {2'b00, v.alt | v.dir[5:0]};
  endfunction
  function automatic logic [7:0] m_out(vec_t v);
    return {2'b00, (v.alt & v.xa) | (~v.alt & v.latch[5:0])};
  endfunction
  function automatic logic [7:0] m_pu(vec_t v);
    return {2'b00, v.pull & ~v.dir[5:0] & ~v.alt};
  endfunction
  function automatic logic [7:0] m_rd(vec_t v);
    logic [7:0] m;
    m = {2'b00, v.dir[5:0] & ~v.alt};
    return (v.latch & m) | (v.pin & ~m);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; xaddr_in = '0;
    do_reset();

    // R1 reset state
    rd(A_DIR, r);  check("R1 dir", r, 8'h00);
    rd(A_ALT, r);  check("R1 alt", r, 8'h00);
    rd(A_PULL, r); check("R1 pull", r, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 pu", pin_pu, 8'h00);

    // vector table: R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(A_DIR, VECS[i].dir);
      wr(A_ALT, {2'b00, VECS[i].alt});
      wr(A_PULL, {2'b00, VECS[i].pull});
      wr(A_DATA, VECS[i].latch);
      @(negedge clk);
      pin_in = VECS[i].pin; xaddr_in = VECS[i].xa;
      #1;
      check("R3/R4 oe", pin_oe, m_oe(VECS[i]));
      check("R3/R4 out", pin_out, m_out(VECS[i]));
      check("R7 pu", pin_pu, m_pu(VECS[i]));
      rd(A_DATA, r); check("R6 data read", r, m_rd(VECS[i]));
    end

    // R2 upper pins never driven
    wr(A_ALT, 8'h00); wr(A_DIR, 8'hFF); wr(A_DATA, 8'hFF);
    #1 check("R2 oe top", {6'b0, pin_oe[7:6]}, 8'h00);
    check("R2 out top", {6'b0, pin_out[7:6]}, 8'h00);

    // R8 analog select follows upper pins
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pin_in = {k[1:0], 6'h15};
      #1 check("R8 an_sel", {6'b0, an_sel}, {6'b0, k[1:0]});
    end

    // R5 hidden write in alternate mode
    wr(A_DIR, 8'h3F); wr(A_ALT, 8'h3F);
    @(negedge clk); xaddr_in = 6'h15;
    wr(A_DATA, 8'h0A);
    #1 check("R5 pin held", pin_out, 8'h15);
    wr(A_ALT, 8'h00);
    #1 check("R5 latch revealed", pin_out, 8'h0A);

    // R9 map: unmapped read zero, unmapped write ignored, upper bits zero
    rd(8'h10, r); check("R9 unmapped read", r, 8'h00);
    wr(8'h10, 8'hFF); wr(8'h7B, 8'hFF);
    rd(A_DIR, r);  check("R9 dir kept", r, 8'h3F);
    rd(A_ALT, r);  check("R9 alt kept", r, 8'h00);
    wr(A_PULL, 8'hFF);
    rd(A_PULL, r); check("R9 pull width", r, 8'h3F);

    // R10 latch survives reset
    wr(A_DATA, 8'hA5);
    do_reset();
    check("R10 oe cleared", pin_oe, 8'h00);
    wr(A_DIR, 8'h3F);
    @(negedge clk); pin_in = 8'hC0;
    rd(A_DATA, r); check("R10 latch kept", r, 8'hE5);
    check("R10 pin", pin_out, 8'h25);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule